// File: doc/BRIEF.md
# Paged Serial Configuration Readout Controller

This block is the read side of a serial configuration memory that streams a bitstream into an FPGA. A bit counter picks one bit of the current array word and an address counter walks the array. Readout runs while the chip enable is low and the combined reset/output-enable pin is high. When that pin goes low, both counters return to the start of the active partition.

A two-bit page select, qualified by a page-enable input, divides the address space into four equal partitions, each with its own start and top address. With paging off, the whole space is one partition. A cascade chip-enable output goes low when the top address of the partition is reached, so the next device in a daisy chain can take over. That output then follows the chip enable until the output enable drops. After that it stays high until the partition has been read through to its top again.

A low serial-enable input selects programming mode. In that mode the readout path is parked: the chip enable, the reset/output-enable pin and the page inputs have no effect.

Top module: `cfg_readout`

## Requirements
- R1: While readout is active, each rising clock shifts out one bit of the word at `rd_addr`, most significant bit first. After the last bit of a word, the bit counter returns to bit 0 and `rd_addr` increments by one.
- R2: With `page_en`=1 and `ser_en`=1, partition k (the value of `page_sel`) starts at k×P and ends at (k+1)×P−1. P is 2^(ADDR_W−2), so `page_sel` forms the two most significant address bits.
- R3: With `page_en`=0, `page_sel` is ignored and the partition runs from 0 to 2^ADDR_W−1.
- R4: With `ser_en`=1 and `oe_rstn`=0, the next clock edge clears the bit counter and loads `rd_addr` with the partition start address.
- R5: With `ser_en`=1, `oe_rstn`=1 and `ce_n`=1, both counters hold their values.
- R6: `dout_en` is high exactly when `ser_en`=1, `ce_n`=0 and `oe_rstn`=1, and `dout` is 0 whenever `dout_en` is low.
- R7: `rd_addr` saturates at the partition top address and does not wrap.
- R8: `ceo_n` goes low while `rd_addr` equals the partition top address and readout is active. It is never low unless `ser_en`=1, `ce_n`=0 and `oe_rstn`=1.
- R9: Once `ce_n` rises at the top address, `ceo_n` follows `ce_n`. After the next low on `oe_rstn`, `ceo_n` stays high until readout has again reached the partition top address, and goes low on the following cycle.
- R10: With `ser_en`=0, the counters hold, `dout_en`=0 and `ceo_n`=1, whatever `ce_n`, `oe_rstn`, `page_en` and `page_sel` do.
- R11: A low on `rst_n` at a clock edge clears the bit counter, loads the partition start address and re-arms the cascade output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge advances the readout |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_rstn | input | 1 | High: output enable; low: counter clear |
| ser_en | input | 1 | High: readout mode; low: programming mode |
| page_en | input | 1 | Enables partitioning by `page_sel` |
| page_sel | input | 2 | Partition index |
| rd_word | input | WORD_W | Array word at `rd_addr` |
| rd_addr | output | ADDR_W | Array word address |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | Serial data driver enable |
| ceo_n | output | 1 | Active-low cascade chip enable for the next device |

## Verification
The assertions assume that `page_sel` and `page_en` change only while `oe_rstn` is low or `ser_en` is low, so the top address that the saturation check compares against holds still during a read. The bench meets this by changing the page inputs only together with a counter clear, or while in programming mode. It also keeps `rd_word` a pure function of `rd_addr`, the way the storage array behaves, so a change in the serial data can only come from the counters.

// File: rtl/cfg_readout_pkg.sv
// Shared types for the serial configuration readout controller.
// Assumes nothing beyond a standard SystemVerilog elaboration.
package cfg_readout_pkg;

    // Cascade output phases: armed (assert at top), following CE, held high.
    typedef enum logic [1:0] {
        CAS_ARMED  = 2'd0,
        CAS_FOLLOW = 2'd1,
        CAS_HELD   = 2'd2
    } cas_state_t;

endpackage

// File: rtl/cfg_page_decode.sv
// Partition decoder: turns the page select and page enable into the start
// and top word addresses of the active partition.
// Assumes ADDR_W >= 3 so that each quarter holds at least two words.
module cfg_page_decode #(
    parameter int ADDR_W = 18
) (
    input  logic              ser_en,
    input  logic              page_en,
    input  logic [1:0]        page_sel,
    output logic [ADDR_W-1:0] part_start,
    output logic [ADDR_W-1:0] part_top
);
    localparam int OFS_W = ADDR_W - 2;

    logic paged;
    assign paged = page_en & ser_en;

    // Select quarter bounds when paging applies, otherwise the full space.
    always_comb begin
        if (paged) begin
            part_start = {page_sel, {OFS_W{1'b0}}};
            part_top   = {page_sel, {OFS_W{1'b1}}};
        end else begin
            part_start = '0;
            part_top   = '1;
        end
    end
endmodule

// File: rtl/cfg_read_counter.sv
// Bit and word-address counters for the serial readout.
// The bit index counts 0..WORD_W-1 and the address steps on its wrap,
// saturating at the partition top. Assumes WORD_W is a power of two.
module cfg_read_counter #(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 8,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ce_n,
    input  logic              oe_rstn,
    input  logic [ADDR_W-1:0] part_start,
    input  logic [ADDR_W-1:0] part_top,
    output logic [ADDR_W-1:0] addr,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              at_top,
    output logic              active
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    assign active = ser_en & ~ce_n & oe_rstn;
    assign at_top = (addr == part_top);

    // Clear on reset or OE low; step bit, then address, while active.
    always_ff @(posedge clk) begin
        if (!rst_n || (ser_en && !oe_rstn)) begin
            addr    <= part_start;
            bit_idx <= '0;
        end else if (active) begin
            if (bit_idx == LAST_BIT) begin
                bit_idx <= '0;
                if (addr < part_top) begin
                    addr <= addr + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_cascade_ctl.sv
// Cascade chip-enable generator. Asserts at the partition top, then follows
// CE until OE drops, then holds high until the top is reached again.
// Assumes at_top and active come from the read counter of the same cycle.
module cfg_cascade_ctl
    import cfg_readout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_en,
    input  logic ce_n,
    input  logic oe_rstn,
    input  logic at_top,
    input  logic active,
    output logic ceo_n
);
    cas_state_t state_q, state_d;

    // Next-phase selection; frozen in programming mode.
    always_comb begin
        state_d = state_q;
        if (ser_en) begin
            unique case (state_q)
                CAS_ARMED:  if (at_top && oe_rstn && ce_n) state_d = CAS_FOLLOW;
                CAS_FOLLOW: if (!oe_rstn)                  state_d = CAS_HELD;
                CAS_HELD:   if (active && at_top)          state_d = CAS_ARMED;
                default:                                   state_d = CAS_ARMED;
            endcase
        end
    end

    // Phase register with synchronous reset to armed.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAS_ARMED;
        else        state_q <= state_d;
    end

    // Output decode per phase.
    always_comb begin
        if (!ser_en) begin
            ceo_n = 1'b1;
        end else begin
            unique case (state_q)
                CAS_ARMED:  ceo_n = ~(active & at_top);
                CAS_FOLLOW: ceo_n = ~oe_rstn | ce_n;
                default:    ceo_n = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_readout.sv
// Paged serial configuration readout controller (top).
// Decodes the partition, runs the bit/address counters, serialises the
// array word MSB first and drives the cascade chip enable.
// Assumes rd_word is the array content at rd_addr in the same cycle.
module cfg_readout #(
    parameter int ADDR_W = 18,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_rstn,
    input  logic              ser_en,
    input  logic              page_en,
    input  logic [1:0]        page_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dout,
    output logic              dout_en,
    output logic              ceo_n
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [ADDR_W-1:0] page_start;
    logic [ADDR_W-1:0] page_top;
    logic [BIT_W-1:0]  bit_idx;
    logic              at_top;
    logic              active;
    logic [WORD_W-1:0] word_rev;

    cfg_page_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ser_en     (ser_en),
        .page_en    (page_en),
        .page_sel   (page_sel),
        .part_start (page_start),
        .part_top   (page_top)
    );

    cfg_read_counter #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_en     (ser_en),
        .ce_n       (ce_n),
        .oe_rstn    (oe_rstn),
        .part_start (page_start),
        .part_top   (page_top),
        .addr       (rd_addr),
        .bit_idx    (bit_idx),
        .at_top     (at_top),
        .active     (active)
    );

    cfg_cascade_ctl u_cas (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_en  (ser_en),
        .ce_n    (ce_n),
        .oe_rstn (oe_rstn),
        .at_top  (at_top),
        .active  (active),
        .ceo_n   (ceo_n)
    );

    // Reverse the word so bit index 0 selects the MSB.
    for (genvar g = 0; g < WORD_W; g++) begin : g_rev
        assign word_rev[g] = rd_word[WORD_W-1-g];
    end

    // Serial data, forced low while the driver is off.
    assign dout_en = active;
    assign dout    = active & word_rev[bit_idx];
endmodule

// File: rtl/cfg_readout_chk.sv
// Property checker for cfg_readout, bound into every instance.
// Assumes page inputs only change while OE is low or in programming mode.
module cfg_readout_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_rstn,
    input logic              ser_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              dout,
    input logic              dout_en,
    input logic              ceo_n,
    input logic [ADDR_W-1:0] page_start,
    input logic [ADDR_W-1:0] page_top
);
    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ser_en) && $past(oe_rstn) && rd_addr != $past(rd_addr))
        |-> rd_addr == $past(rd_addr) + 1'b1);

    // R4
    oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && !oe_rstn) |=> rd_addr == $past(page_start));

    // R5
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && ce_n && oe_rstn) |=> $stable(rd_addr));

    // R6
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout);

    // R7
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && oe_rstn && rd_addr == page_top) |=> rd_addr == $past(rd_addr));

    // R8
    ceo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n |-> (ser_en && !ce_n && oe_rstn));

    // R10
    prog_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> $stable(rd_addr));

    // R10
    prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (ceo_n && !dout_en));
endmodule

bind cfg_readout cfg_readout_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_rstn    (oe_rstn),
    .ser_en     (ser_en),
    .rd_addr    (rd_addr),
    .dout       (dout),
    .dout_en    (dout_en),
    .ceo_n      (ceo_n),
    .page_start (page_start),
    .page_top   (page_top)
);

// File: tb/cfg_readout_bench.sv
`timescale 1ns/100ps
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks on page bases, saturation and the cascade output.
module cfg_readout_bench;
    localparam int AW = 6;
    localparam int WW = 8;
    localparam int PW = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_rstn = 1'b0;
    logic          ser_en = 1'b1;
    logic          page_en = 1'b1;
    logic [1:0]    page_sel = 2'd2;
    logic [WW-1:0] rd_word;
    logic [AW-1:0] rd_addr;
    logic          dout, dout_en, ceo_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 90) ^ (a >> 2));
    endfunction

    assign rd_word = pat(int'(rd_addr));

    cfg_readout #(.ADDR_W(AW), .WORD_W(WW)) u_cfg_readout (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_rstn(oe_rstn),
        .ser_en(ser_en), .page_en(page_en), .page_sel(page_sel),
        .rd_word(rd_word), .rd_addr(rd_addr), .dout(dout),
        .dout_en(dout_en), .ceo_n(ceo_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state: 0 armed, 1 following CE, 2 held high.
    int m_addr = 0, m_bit = 0, m_st = 0;
    bit m_valid = 1'b0;

    always @(negedge clk) begin
        int st, tp, e_dout, e_ceo;
        bit act, paged, top_hit;
        if (!done) begin
            paged = page_en && ser_en;
            st = paged ? int'(page_sel) * PW : 0;
            tp = paged ? st + PW - 1 : (1 << AW) - 1;
            act = ser_en && !ce_n && oe_rstn;
            top_hit = (m_addr == tp);
            e_dout = act ? int'(pat(m_addr) >> (7 - m_bit)) & 1 : 0;
            if (!ser_en) e_ceo = 1;
            else if (m_st == 0) e_ceo = (act && top_hit) ? 0 : 1;
            else if (m_st == 1) e_ceo = (!oe_rstn || ce_n) ? 1 : 0;
            else e_ceo = 1;
            if (m_valid) begin
                chk("R2 rd_addr model", int'(rd_addr), m_addr);
                chk("R1 dout model", int'(dout), e_dout);
                chk("R6 dout_en model", int'(dout_en), int'(act));
                chk("R9 ceo_n model", int'(ceo_n), e_ceo);
            end
            if (!rst_n) begin
                m_addr = st; m_bit = 0; m_st = 0; m_valid = 1'b1;
            end else if (ser_en) begin
                case (m_st)
                    0: if (top_hit && oe_rstn && ce_n) m_st = 1;
                    1: if (!oe_rstn) m_st = 2;
                    default: if (act && top_hit) m_st = 0;
                endcase
                if (!oe_rstn) begin
                    m_addr = st; m_bit = 0;
                end else if (act) begin
                    if (m_bit == WW - 1) begin
                        m_bit = 0;
                        if (m_addr < tp) m_addr++;
                    end else m_bit++;
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(2);
        chk("R11 reset loads page 2 base", int'(rd_addr), 32);
        chk("R6 reset dout_en", int'(dout_en), 0);
        chk("R11 reset ceo_n", int'(ceo_n), 1);
        rst_n = 1'b1;
        oe_rstn = 1'b1; ce_n = 1'b0;
        step(119);
        chk("R1 address after 119 bits", int'(rd_addr), 46);
        chk("R8 ceo_n before top", int'(ceo_n), 1);
        step(1);
        chk("R2 page 2 top", int'(rd_addr), 47);
        chk("R8 ceo_n at top", int'(ceo_n), 0);
        step(20);
        chk("R7 saturate at top", int'(rd_addr), 47);
        ce_n = 1'b1; step(1);
        chk("R9 ceo_n follows CE high", int'(ceo_n), 1);
        ce_n = 1'b0; step(1);
        chk("R9 ceo_n follows CE low", int'(ceo_n), 0);
        oe_rstn = 1'b0; step(1);
        chk("R4 OE low clears to base", int'(rd_addr), 32);
        chk("R9 ceo_n high on OE low", int'(ceo_n), 1);
        oe_rstn = 1'b1; step(60);
        chk("R1 mid-page address", int'(rd_addr), 39);
        chk("R9 sticky high mid-read", int'(ceo_n), 1);
        ce_n = 1'b1; step(5);
        chk("R5 CE high holds address", int'(rd_addr), 39);
        chk("R5 CE high driver off", int'(dout_en), 0);
        ce_n = 1'b0; step(60);
        chk("R9 top reached again", int'(rd_addr), 47);
        chk("R9 still high on arrival", int'(ceo_n), 1);
        step(1);
        chk("R9 re-armed asserts", int'(ceo_n), 0);
        oe_rstn = 1'b0;
        for (int p = 0; p < 4; p++) begin
            page_sel = 2'(p); step(1);
            chk("R2 page base", int'(rd_addr), p * PW);
        end
        page_en = 1'b0; page_sel = 2'd3; step(1);
        chk("R3 unpaged base", int'(rd_addr), 0);
        oe_rstn = 1'b1; step(63 * 8);
        chk("R3 unpaged top", int'(rd_addr), 63);
        chk("R8 unpaged ceo_n", int'(ceo_n), 0);
        ser_en = 1'b0; step(10);
        chk("R10 prog mode holds", int'(rd_addr), 63);
        chk("R10 prog mode driver off", int'(dout_en), 0);
        chk("R10 prog mode ceo_n", int'(ceo_n), 1);
        oe_rstn = 1'b0; page_en = 1'b1; page_sel = 2'd1; step(3);
        chk("R10 OE ignored in prog mode", int'(rd_addr), 63);
        oe_rstn = 1'b1; page_en = 1'b0; step(1);
        ser_en = 1'b1; step(1);
        chk("R8 back in readout at top", int'(ceo_n), 0);
        step(4);
        finish_run();
    end
endmodule